// File: doc/BRIEF.md
# Staged UART Line-Control Register Bank

This block holds the frame configuration of a UART as a 23-bit line-control word. The word is split across three bus-visible registers: a low part and a mid part, each carrying 8 bits of the baud divisor, and a high part that carries the character format flags. Software can write the low and mid parts in any order. Those writes only fill holding registers. A write to the high part captures the held divisor together with the new flag byte into the active word in one clock edge, so the transmitter and receiver never see a half-updated configuration.

The active word drives a set of configuration outputs: the 16-bit divisor, the word-length code, a decoded data-bit count, FIFO enable, two-stop-bit select, even parity select, parity enable and send break. The bus is a plain word-addressed port with an address, a write strobe, write data and combinational read data. The UART shifters, baud generator and FIFOs sit outside this block.

Top module: `lcr_bank`

## Requirements
- R1: The active word is 23 bits: divisor bits 7:0 come from the low register (address 0), divisor bits 15:8 from the mid register (address 1), and the 7 control bits from the high register (address 2).
- R2: A write to address 2 commits the word. The outputs keep their old values in the cycle of the write strobe and show the new word after the next rising clock edge.
- R3: A write to address 0 or address 1 alone leaves every configuration output unchanged.
- R4: Writing low, then mid, then high commits the same word as writing mid, then low, then high with the same data.
- R5: When only one of the low or mid parts is written before a high write, the other part commits its previously held value.
- R6: The word-length code on `cfg_wlen` selects 5, 6, 7 or 8 data bits for the codes 00, 01, 10 and 11, and `cfg_data_bits` shows that count as a binary number.
- R7: In the high register, bits 6:5 are the word-length code, bit 4 is FIFO enable, bit 3 is two stop bits, bit 2 is even parity, bit 1 is parity enable and bit 0 is send break.
- R8: Synchronous reset clears the held low and mid parts and the active word, so every output and every register read returns zero.
- R9: Reads of addresses 0 and 1 return the held parts, and a read of address 2 returns the committed control bits. Other addresses read zero, and writes to them change nothing.
- R10: Bits above bit 7 of the low and mid registers, and above bit 6 of the high register, read as zero and ignore the value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| cfg_divisor | output | 16 | Committed baud divisor |
| cfg_wlen | output | 2 | Committed word-length code |
| cfg_data_bits | output | 4 | Data bits per character, 5 to 8 |
| cfg_fifo_en | output | 1 | FIFO enable |
| cfg_two_stop | output | 1 | Two stop bits |
| cfg_even_par | output | 1 | Even parity select |
| cfg_par_en | output | 1 | Parity enable |
| cfg_break | output | 1 | Send break |

## Verification
The hardest situation to reach is a divisor whose two held halves differ from the committed halves while the outputs still show the old word. Only then does a missing hold stage or a premature commit show up. The bench loads distinct low and mid values without a high write, checks that the outputs stay put while both halves read back as held, and only then commits. It repeats the commit with the two writes in the opposite order and with a single half rewritten, so that a half which leaks or is lost shows a changed divisor.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

    localparam int HALF_W = 8;
    localparam int DIV_W  = 2 * HALF_W;
    localparam int CTRL_W = 7;
    localparam int WORD_W = DIV_W + CTRL_W;

    // Control byte layout: wlen[6:5] fifo[4] stop2[3] even[2] par[1] brk[0]
    typedef struct packed {
        logic [1:0] wlen;
        logic       fifo_en;
        logic       two_stop;
        logic       even_par;
        logic       par_en;
        logic       brk;
    } line_ctrl_t;

    typedef struct packed {
        line_ctrl_t             ctrl;
        logic [DIV_W-1:0]       divisor;
    } line_word_t;

    typedef enum logic [1:0] {
        SEL_LOW  = 2'd0,
        SEL_MID  = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [31:0] a);
        case (a)
            32'd0:   return SEL_LOW;
            32'd1:   return SEL_MID;
            32'd2:   return SEL_HIGH;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [3:0] bits_per_char(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

endpackage

// File: rtl/lcr_stage.sv
module lcr_stage
    import lcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        wr_half,
    input  logic [HALF_W-1:0] wdata,
    output logic [DIV_W-1:0]  held
);

    for (genvar g = 0; g < 2; g++) begin : g_half
        logic [HALF_W-1:0] part_q;

        always_ff @(posedge clk) begin
            if (rst)
                part_q <= '0;
            else if (wr_half[g])
                part_q <= wdata;
        end

        assign held[g*HALF_W +: HALF_W] = part_q;
    end

    // A write to one half never disturbs the other half
    assert_other_half_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_half == 2'b10) |=> $stable(held[HALF_W-1:0]));
    assert_other_half_mid_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_half == 2'b01) |=> $stable(held[DIV_W-1:HALF_W]));

endmodule

// File: rtl/lcr_commit.sv
module lcr_commit
    import lcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic             stage_wr,
    input  logic [DIV_W-1:0] held,
    input  line_ctrl_t       ctrl_in,
    output line_word_t       active
);

    line_word_t active_q;

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= '0;
        else if (commit)
            active_q <= '{ctrl: ctrl_in, divisor: held};
    end

    assign active = active_q;

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (active_q == '0));

    assert_commit_ctrl_R2: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active_q.ctrl == $past(ctrl_in)));

    assert_commit_div_R1: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active_q.divisor == $past(held)));

    assert_stage_only_R3: assert property (@(posedge clk) disable iff (rst)
        (stage_wr && !commit) |=> $stable(active_q));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active_q));

endmodule

// File: rtl/lcr_bank.sv
module lcr_bank
    import lcr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [15:0]       cfg_divisor,
    output logic [1:0]        cfg_wlen,
    output logic [3:0]        cfg_data_bits,
    output logic              cfg_fifo_en,
    output logic              cfg_two_stop,
    output logic              cfg_even_par,
    output logic              cfg_par_en,
    output logic              cfg_break
);

    reg_sel_t          sel;
    logic [1:0]        wr_half;
    logic              wr_high;
    logic [DIV_W-1:0]  held;
    line_word_t        active;
    line_ctrl_t        ctrl_in;
    logic              unused_wdata_hi;

    assign sel     = decode_addr(32'(bus_addr));
    assign wr_half = {bus_wr && (sel == SEL_MID), bus_wr && (sel == SEL_LOW)};
    assign wr_high = bus_wr && (sel == SEL_HIGH);
    assign ctrl_in = line_ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:HALF_W];

    lcr_stage i_stage (
        .clk     (clk),
        .rst     (rst),
        .wr_half (wr_half),
        .wdata   (bus_wdata[HALF_W-1:0]),
        .held    (held)
    );

    lcr_commit i_commit (
        .clk      (clk),
        .rst      (rst),
        .commit   (wr_high),
        .stage_wr (|wr_half),
        .held     (held),
        .ctrl_in  (ctrl_in),
        .active   (active)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_LOW:  bus_rdata[HALF_W-1:0] = held[HALF_W-1:0];
            SEL_MID:  bus_rdata[HALF_W-1:0] = held[DIV_W-1:HALF_W];
            SEL_HIGH: bus_rdata[CTRL_W-1:0] = active.ctrl;
            default:  bus_rdata = '0;
        endcase
    end

    assign cfg_divisor   = active.divisor;
    assign cfg_wlen      = active.ctrl.wlen;
    assign cfg_data_bits = bits_per_char(active.ctrl.wlen);
    assign cfg_fifo_en   = active.ctrl.fifo_en;
    assign cfg_two_stop  = active.ctrl.two_stop;
    assign cfg_even_par  = active.ctrl.even_par;
    assign cfg_par_en    = active.ctrl.par_en;
    assign cfg_break     = active.ctrl.brk;

    assert_rsvd_read_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (bus_rdata[DATA_W-1:HALF_W] == '0));

    assert_data_bits_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_data_bits >= 4'd5) && (cfg_data_bits <= 4'd8));

    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_NONE) |=> ($stable(held) && $stable(active)));

endmodule

// File: tb/test_lcr_bank.sv
module test_lcr_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] cfg_divisor;
    logic [1:0]  cfg_wlen;
    logic [3:0]  cfg_data_bits;
    logic        cfg_fifo_en, cfg_two_stop, cfg_even_par, cfg_par_en, cfg_break;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench's own expectation, built from the requirements
    logic [7:0]  m_low = '0, m_mid = '0;
    logic [15:0] m_div = '0;
    logic [6:0]  m_ctrl = '0;

    always #2.5 clk = ~clk;

    lcr_bank i_lcr_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_divisor(cfg_divisor), .cfg_wlen(cfg_wlen),
        .cfg_data_bits(cfg_data_bits), .cfg_fifo_en(cfg_fifo_en),
        .cfg_two_stop(cfg_two_stop), .cfg_even_par(cfg_even_par),
        .cfg_par_en(cfg_par_en), .cfg_break(cfg_break)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] out_ctrl();
        return {cfg_wlen, cfg_fifo_en, cfg_two_stop, cfg_even_par, cfg_par_en, cfg_break};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            4'd0: m_low = d[7:0];
            4'd1: m_mid = d[7:0];
            4'd2: begin m_div = {m_mid, m_low}; m_ctrl = d[6:0]; end
            default: ;
        endcase
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic check_outputs(input string req);
        check(req, {16'd0, cfg_divisor}, {16'd0, m_div});
        check(req, {25'd0, out_ctrl()}, {25'd0, m_ctrl});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R8 divisor", {16'd0, cfg_divisor}, 32'd0);
        check("R8 ctrl", {25'd0, out_ctrl()}, 32'd0);
        for (int a = 0; a < 3; a++) begin
            rd(4'(a), v);
            check("R8 read", v, 32'd0);
        end
    endtask

    task automatic t_hold_only();
        logic [31:0] v;
        wr(4'd0, 32'hA5);
        wr(4'd1, 32'h3C);
        check("R3 divisor held back", {16'd0, cfg_divisor}, 32'd0);
        check("R3 ctrl held back", {25'd0, out_ctrl()}, 32'd0);
        rd(4'd0, v); check("R9 low held", v, 32'hA5);
        rd(4'd1, v); check("R9 mid held", v, 32'h3C);
        rd(4'd2, v); check("R9 high committed", v, 32'd0);
        wr(4'd2, 32'h0);
        check("R1 divisor commit", {16'd0, cfg_divisor}, 32'h3CA5);
    endtask

    task automatic t_timing();
        logic [31:0] v;
        @(negedge clk);
        bus_addr = 4'd2; bus_wdata = 32'h55; bus_wr = 1'b1;
        #1 check("R2 no change in strobe cycle", {25'd0, out_ctrl()}, {25'd0, m_ctrl});
        @(negedge clk);
        bus_wr = 1'b0;
        m_ctrl = 7'h55; m_div = {m_mid, m_low};
        check_outputs("R2 one edge later");
        rd(4'd2, v); check("R9 high read", v, 32'h55);
    endtask

    task automatic t_order();
        logic [15:0] d1;
        logic [6:0]  c1;
        wr(4'd0, 32'h11); wr(4'd1, 32'h22); wr(4'd2, 32'h03);
        d1 = cfg_divisor; c1 = out_ctrl();
        check("R4 low-mid-high", {16'd0, d1}, 32'h2211);
        wr(4'd0, 32'h44); wr(4'd1, 32'h33); wr(4'd2, 32'h7F);
        wr(4'd1, 32'h22); wr(4'd0, 32'h11); wr(4'd2, 32'h03);
        check("R4 mid-low-high divisor", {16'd0, cfg_divisor}, {16'd0, d1});
        check("R4 mid-low-high ctrl", {25'd0, out_ctrl()}, {25'd0, c1});
    endtask

    task automatic t_partial();
        wr(4'd0, 32'h99); wr(4'd2, 32'h01);
        check("R5 low only", {16'd0, cfg_divisor}, 32'h2299);
        wr(4'd1, 32'h77); wr(4'd2, 32'h01);
        check("R5 mid only", {16'd0, cfg_divisor}, 32'h7799);
        check_outputs("R5 model");
    endtask

    task automatic t_fields();
        for (int w = 0; w < 4; w++) begin
            wr(4'd2, 32'(w << 5));
            check("R6 wlen", {30'd0, cfg_wlen}, 32'(w));
            check("R6 data bits", {28'd0, cfg_data_bits}, 32'(5 + w));
        end
        for (int b = 0; b < 5; b++) begin
            wr(4'd2, 32'(1 << b));
            check("R7 flag position",
                  {27'd0, cfg_fifo_en, cfg_two_stop, cfg_even_par, cfg_par_en, cfg_break},
                  32'(1 << b));
        end
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(4'd0, 32'hFFFF_FF5A);
        rd(4'd0, v); check("R10 low reserved", v, 32'h5A);
        wr(4'd1, 32'hABCD_EF00);
        rd(4'd1, v); check("R10 mid reserved", v, 32'h00);
        wr(4'd2, 32'hFFFF_FF80);
        rd(4'd2, v); check("R10 high reserved", v, 32'h0);
        check_outputs("R10 outputs");
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(4'd0, 32'h12); wr(4'd1, 32'h34); wr(4'd2, 32'h2A);
        wr(4'd3, 32'hFFFF_FFFF); wr(4'd15, 32'hFFFF_FFFF);
        rd(4'd3, v);  check("R9 unmapped read 3", v, 32'd0);
        rd(4'd15, v); check("R9 unmapped read 15", v, 32'd0);
        rd(4'd0, v);  check("R9 low kept", v, 32'h12);
        rd(4'd1, v);  check("R9 mid kept", v, 32'h34);
        check_outputs("R9 outputs kept");
    endtask

    task automatic t_reset_again();
        logic [31:0] v;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_low = '0; m_mid = '0; m_div = '0; m_ctrl = '0;
        check_outputs("R8 reset mid-run");
        rd(4'd0, v); check("R8 low cleared", v, 32'd0);
        rd(4'd1, v); check("R8 mid cleared", v, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hold_only();
        t_timing();
        t_order();
        t_partial();
        t_fields();
        t_reserved();
        t_unmapped();
        t_reset_again();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule